// File: doc/BRIEF.md
# Gate On-Time Limiter with Blanking

This block decides how long each gate pulse of a flyback controller stays on. A one-cycle start request turns the gate on. From then on four conditions compete to end the pulse. The first is a constant on-time comparator trip. The second is a cycle-by-cycle current-limit trip, which is ignored for a short blanking window after turn-on. The third is a hard ceiling on pulse length. The fourth is a programmable minimum on-time floor, which holds back a comparator trip that arrives too early. The minimum on-time comes in as a count, because the analog side derives it from a sampled line-related current.

A run-enable input lets the fault logic kill the gate at any time. A two-bit output reports which condition ended the most recent pulse. All times are counted in clock cycles. A pulse "length" is the number of clock cycles the gate is high. "Elapsed" is the 1-based index of the current cycle within the pulse.

Top module: `gate_ontime_limiter`

## Requirements
- R1: When `run_en_i` is high and the gate is low, a high `start_i` at a clock edge drives `gate_o` high after that edge.
- R2: A comparator trip (`otc_trip_i` high) in the cycle with elapsed e, where e ≥ `min_on_i`, ends the pulse with length e, and `end_cause_o` becomes 1.
- R3: `ilim_trip_i` has no effect while elapsed ≤ `LEB_CYC`. In the first cycle after that window in which it is high, it ends the pulse with length equal to that elapsed value, and `end_cause_o` becomes 2.
- R4: No pulse exceeds `MAX_ON_CYC` cycles. A pulse that no other condition ends lasts exactly `MAX_ON_CYC` cycles, and `end_cause_o` becomes 3.
- R5: A comparator trip seen at any elapsed value below `min_on_i`, even a one-cycle pulse, is remembered. The pulse then ends with length `min_on_i`, provided that is within the ceiling, and `end_cause_o` becomes 1.
- R6: The minimum on-time never delays a current-limit termination. When several conditions end a pulse in the same cycle, the current limit wins over the comparator, and the comparator wins over the ceiling.
- R7: A `start_i` that arrives while the gate is high is ignored: the pulse length and cause are the same as without it.
- R8: With `run_en_i` low, `gate_o` is low after the next clock edge. An aborted pulse sets `end_cause_o` to 0. Start requests are ignored while `run_en_i` is low.
- R9: After reset, `gate_o` is 0 and `end_cause_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Cycle-start request |
| otc_trip_i | input | 1 | Constant on-time comparator trip |
| ilim_trip_i | input | 1 | Current-limit comparator trip |
| run_en_i | input | 1 | Fault enable; low forces the gate off |
| min_on_i | input | CNT_W | Minimum on-time in cycles |
| gate_o | output | 1 | Gate drive |
| end_cause_o | output | 2 | Cause of the last pulse end: 0 abort/none, 1 comparator, 2 current limit, 3 ceiling |

## Verification
The bench builds the block with `CNT_W=8`, `LEB_CYC=4` and `MAX_ON_CYC=40`. A 40-cycle ceiling lets many random pulses run into it in a short run. A 4-cycle blanking window puts the edge between a blanked and an honoured current-limit trip within a few cycles of turn-on. Random minimum counts up to 50 cover floors both below and above the ceiling. This exposes how the floor interacts with the ceiling and with the priority order.

// File: rtl/gol_pkg.sv
package gol_pkg;
  typedef enum logic [1:0] {
    C_NONE = 2'd0,
    C_CMP  = 2'd1,
    C_ILIM = 2'd2,
    C_TMAX = 2'd3
  } cause_e;

  // current limit is honoured only once the blanking window has passed
  function automatic logic ilim_open(input logic [15:0] elapsed, input logic [15:0] leb);
    return elapsed > leb;
  endfunction

  // floor reached when the gate has been on for at least min cycles
  function automatic logic floor_met(input logic [15:0] elapsed, input logic [15:0] min_on);
    return elapsed >= min_on;
  endfunction
endpackage

// File: rtl/gol_ontime_ctr.sv
module gol_ontime_ctr #(
  parameter int CNT_W      = 12,
  parameter int MAX_ON_CYC = 2350
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           run,
  output logic [CNT_W:0] elapsed
);
  localparam int EW = CNT_W + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_ON_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr)                  cnt_q <= '0;
    else if (run && cnt_q < LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign elapsed = EW'(cnt_q) + EW'(1);
endmodule

// File: rtl/gol_term_arb.sv
module gol_term_arb
  import gol_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int LEB_CYC    = 20,
  parameter int MAX_ON_CYC = 2350
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             gate_on,
  input  logic [CNT_W:0]   elapsed,
  input  logic [CNT_W-1:0] min_on,
  input  logic             cmp_trip,
  input  logic             ilim_trip,
  output logic             kill,
  output cause_e           cause_next
);
  localparam logic [15:0] LEB_E = 16'(LEB_CYC);
  localparam logic [15:0] MAX_E = 16'(MAX_ON_CYC);

  logic cmp_seen_q, cmp_any;
  logic kill_ilim, kill_cmp, kill_tmax;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cmp_seen_q <= 1'b0;
    else if (clr)                 cmp_seen_q <= 1'b0;
    else if (gate_on && cmp_trip) cmp_seen_q <= 1'b1;
  end

  assign cmp_any   = cmp_trip | cmp_seen_q;
  assign kill_ilim = gate_on && ilim_trip && ilim_open(16'(elapsed), LEB_E);
  assign kill_cmp  = gate_on && cmp_any && floor_met(16'(elapsed), 16'(min_on));
  assign kill_tmax = gate_on && (16'(elapsed) >= MAX_E);
  assign kill      = kill_ilim | kill_cmp | kill_tmax;

  always_comb begin
    if (kill_ilim)      cause_next = C_ILIM;
    else if (kill_cmp)  cause_next = C_CMP;
    else if (kill_tmax) cause_next = C_TMAX;
    else                cause_next = C_NONE;
  end

  // R5: a remembered trip below the floor must not end the pulse
  p_floor_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && !kill_ilim && !kill_tmax) |-> (16'(elapsed) >= 16'(min_on)));
  // R6: current limit wins over the others in the same cycle
  p_ilim_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    kill_ilim |-> (cause_next == C_ILIM));
endmodule

// File: rtl/gate_ontime_limiter.sv
module gate_ontime_limiter
  import gol_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int LEB_CYC    = 20,
  parameter int MAX_ON_CYC = 2350
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             otc_trip_i,
  input  logic             ilim_trip_i,
  input  logic             run_en_i,
  input  logic [CNT_W-1:0] min_on_i,
  output logic             gate_o,
  output logic [1:0]       end_cause_o
);
  logic           gate_q;
  cause_e         cause_q, cause_next;
  logic           accept, kill;
  logic [CNT_W:0] elapsed;

  assign accept = start_i && run_en_i && !gate_q;

  gol_ontime_ctr #(.CNT_W(CNT_W), .MAX_ON_CYC(MAX_ON_CYC)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(accept), .run(gate_q), .elapsed(elapsed)
  );

  gol_term_arb #(.CNT_W(CNT_W), .LEB_CYC(LEB_CYC), .MAX_ON_CYC(MAX_ON_CYC)) u_arb (
    .clk(clk), .rst_n(rst_n), .clr(accept), .gate_on(gate_q), .elapsed(elapsed),
    .min_on(min_on_i), .cmp_trip(otc_trip_i), .ilim_trip(ilim_trip_i),
    .kill(kill), .cause_next(cause_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= 1'b0;
      cause_q <= C_NONE;
    end else if (!run_en_i) begin
      gate_q <= 1'b0;
      if (gate_q) cause_q <= C_NONE;
    end else if (accept) begin
      gate_q <= 1'b1;
    end else if (gate_q && kill) begin
      gate_q  <= 1'b0;
      cause_q <= cause_next;
    end
  end

  assign gate_o      = gate_q;
  assign end_cause_o = cause_q;

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && run_en_i && !gate_o) |=> gate_o);
  p_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_o) && end_cause_o == 2'(C_ILIM)) |-> ($past(elapsed) > (CNT_W+1)'(LEB_CYC)));
  p_ceiling_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> (elapsed <= (CNT_W+1)'(MAX_ON_CYC)));
  p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_o) && end_cause_o == 2'(C_CMP)) |-> ($past(elapsed) >= (CNT_W+1)'($past(min_on_i))));
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en_i |=> !gate_o);
endmodule

// File: tb/tb_gate_ontime_limiter.sv
module tb_gate_ontime_limiter;
  localparam int CW = 8, LEB = 4, TMAX = 40;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, otc_trip_i = 0, ilim_trip_i = 0, run_en_i = 0;
  logic [CW-1:0] min_on_i = '0;
  logic gate_o;
  logic [1:0] end_cause_o;
  int checks = 0, errors = 0;
  bit done = 0;

  gate_ontime_limiter #(.CNT_W(CW), .LEB_CYC(LEB), .MAX_ON_CYC(TMAX)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .otc_trip_i(otc_trip_i),
    .ilim_trip_i(ilim_trip_i), .run_en_i(run_en_i), .min_on_i(min_on_i),
    .gate_o(gate_o), .end_cause_o(end_cause_o)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference: first elapsed cycle in which some condition ends the pulse
  function automatic void model(input int mn, input int cmp_at, input int ilim_at,
                                output int len, output int cause);
    bit seen = 0;
    len = TMAX; cause = 3;
    for (int e = 1; e <= TMAX; e++) begin
      if (e == cmp_at) seen = 1;
      if (e >= ilim_at && e > LEB) begin len = e; cause = 2; return; end
      if (seen && e >= mn)         begin len = e; cause = 1; return; end
    end
  endfunction

  task automatic pulse(input int mn, input int cmp_at, input int ilim_at,
                       input int extra_start, input string tag);
    int len, cause, got;
    model(mn, cmp_at, ilim_at, len, cause);
    @(negedge clk);
    min_on_i = CW'(mn); start_i = 1;
    @(negedge clk);
    start_i = 0;
    got = 0;
    for (int e = 1; e <= TMAX + 5; e++) begin
      otc_trip_i  = (e == cmp_at);
      ilim_trip_i = (e >= ilim_at);
      start_i     = (e == extra_start);
      @(negedge clk);
      if (!gate_o) begin got = e; break; end
    end
    otc_trip_i = 0; ilim_trip_i = 0; start_i = 0;
    chk(got == len, {tag, " length"}, got, len);
    chk(int'(end_cause_o) == cause, {tag, " cause"}, end_cause_o, cause);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(gate_o == 0, "R9 gate", gate_o, 0);
    chk(end_cause_o == 0, "R9 cause", end_cause_o, 0);
    rst_n = 1; run_en_i = 1;
    @(negedge clk);
    // R1: start raises the gate
    start_i = 1; @(negedge clk); start_i = 0;
    chk(gate_o == 1, "R1 rise", gate_o, 1);
    otc_trip_i = 1; @(negedge clk); otc_trip_i = 0; @(negedge clk);
    pulse(3, 7, 99, 0, "R2 comparator");
    pulse(0, 60, 99, 0, "R4 ceiling");
    pulse(0, 60, 1, 0, "R3 blanked then limit");
    pulse(0, 60, LEB + 1, 0, "R3 first open cycle");
    pulse(12, 2, 99, 0, "R5 floor defers trip");
    pulse(50, 2, 99, 0, "R5 floor above ceiling R4");
    pulse(20, 2, 8, 0, "R6 limit not deferred");
    pulse(0, 9, 9, 0, "R6 limit beats comparator");
    pulse(0, 40, 99, 0, "R6 comparator beats ceiling");
    pulse(5, 15, 99, 3, "R7 start while on");
    // R8: abort mid-pulse
    @(negedge clk); min_on_i = 0; start_i = 1;
    @(negedge clk); start_i = 0;
    @(negedge clk); run_en_i = 0;
    @(negedge clk);
    chk(gate_o == 0, "R8 abort gate", gate_o, 0);
    chk(end_cause_o == 0, "R8 abort cause", end_cause_o, 0);
    start_i = 1; @(negedge clk); start_i = 0;
    chk(gate_o == 0, "R8 start ignored", gate_o, 0);
    run_en_i = 1; @(negedge clk);
    // random mix
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 150; i++) begin
      int mn, ca, ia, xs;
      mn = $urandom_range(0, 50);
      ca = $urandom_range(1, 50);
      ia = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 45) : 99;
      xs = ($urandom_range(0, 4) == 0) ? $urandom_range(1, 10) : 0;
      pulse(mn, ca, ia, xs, "R2 R3 R4 R5 R6 R7 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule